// File: doc/BRIEF.md
# Chained Double-Buffered DMA Channel

This block is one DMA channel that walks a memory buffer one 32-bit word at a time and, when that buffer is used up, moves straight on to a second buffer without a dead cycle. Two pointer pairs hold the buffers. The active pair is a running pointer and an end address, where the end address is one past the last byte. The queued pair is a start and a stop address. Software programs the queued pair and sets an "armed" flag. When the active buffer ends with the flag set, the queued pair is copied into the active pair and the flag clears. When the flag is clear, the channel stops. At every buffer end the channel records the finished buffer's first address and the address one past the last word it moved. If the buffer was promoted from the queued pair, it also keeps a copy of that start/stop pair. Software can read these saved values to find out how long a packet that ended early really was.

Software drives the block through a 32-bit register port with a write strobe and a combinational read. Memory traffic goes through a request port that uses the valid/ready rules. `mem_valid` rises when the channel wants a word at `mem_addr`. While `mem_ready` is low, the request holds with the same address; a register write is the only thing that may change it. A beat completes on a clock edge where both `mem_valid` and `mem_ready` are high, and `mem_err` and `mem_eop` are sampled on that same edge. The moved data itself goes between memory and the peripheral outside this block.

Top module: `chain_dma_channel`

Register index (`reg_addr`):
- 0: control/status
- 1: live pointer (read only)
- 2: pointer load (a write sets the live pointer and the buffer base; a read returns the base)
- 3: end address
- 4: queued start
- 5: queued stop
- 6: saved base
- 7: saved end
- 8: saved queued start
- 9: saved queued stop
- Any other index reads zero.

Control bits on a write:
- bit0: set enable
- bit1: set armed
- bit2: clear done
- bit3: zero the pointers
- bit4: channel reset
- bit5: direction
- bit6: transmit mode

Status bits on a read:
- bit0: enable
- bit1: armed
- bit2: done
- bit3: bus error
- bit5: direction
- bit6: transmit mode

## Requirements
- R1: After `rst_n` the status word reads 0, `irq` is low and `mem_valid` is low. A control write with bit4 set clears enable, armed and bus error. Within the same write, the set bits (bit0, bit1) are applied after the reset, so writing 0x11 leaves only enable set.
- R2: A write to index 2 loads the live pointer, which then reads back at index 1. Once enabled, the channel issues one request per word, beginning at that pointer, and each accepted beat adds 4 to it.
- R3: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr` stays unchanged on the next cycle.
- R4: When an accepted beat brings the pointer up to the end address and armed is clear, done is set, enable clears, `mem_valid` drops, and index 1 reads the end address.
- R5: When the buffer ends with armed set, the queued start and stop become the live pointer and end address, and armed clears. The first beat at the queued start can be accepted on the cycle right after the last beat of the previous buffer.
- R6: At each buffer end, index 6 takes the finished buffer's base and index 7 takes the address one past its last moved word. On a promotion, indices 8 and 9 take the queued start and stop that were used.
- R7: An accepted beat with `mem_eop` high ends the buffer early, with the same effects as reaching the end address. Saved end minus saved base then equals 4 times the number of words moved.
- R8: In transmit mode (status bit6), bit 31 of the end and stop addresses is a flag that the end compare ignores. The saved end keeps that flag in bit 31.
- R9: Done stays set, and `irq` stays high, until a control write with bit2. `irq` is also high while bus error is set.
- R10: An accepted beat with `mem_err` high sets bus error and clears enable. It does not advance the pointer, set done or promote the queued pair, and armed stays as it was.
- R11: `mem_write` is high when direction (bit5) is 0, meaning device to memory, and low when direction is 1, meaning memory to device.
- R12: A control write with bit3 sets the live pointer, base, end, queued start and queued stop to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_valid | output | 1 | Word request pending |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | 32 | Word address of the request |
| mem_write | output | 1 | 1 = store into memory, 0 = load from memory |
| mem_err | input | 1 | Error response for the accepted beat |
| mem_eop | input | 1 | Peripheral marks the accepted beat as the last of the packet |
| irq | output | 1 | Interrupt: done or bus error |

## Verification
The bench targets the boundary between the two buffers. A design that leaves an idle cycle there, or that stops even though armed is set, fails the back-to-back timing check on the first queued beat. Transmit-mode ends carry a flag in bit 31. A design that compares the full word never reaches the end, so it issues extra beats or stalls the run. Early packet end and error responses check the saved registers and the status word. A channel that advanced on an error beat, promoted the queued pair, or counted the short length wrongly shows the wrong pointer, the wrong length, or extra requests. Stalled requests under toggling `mem_ready` check that the address holds, and the reset command written together with set-enable checks the ordering rule.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  localparam int unsigned IDX_W = 4;

  localparam logic [IDX_W-1:0] RI_CSR       = 4'd0;
  localparam logic [IDX_W-1:0] RI_PTR       = 4'd1;
  localparam logic [IDX_W-1:0] RI_PTR_LOAD  = 4'd2;
  localparam logic [IDX_W-1:0] RI_END       = 4'd3;
  localparam logic [IDX_W-1:0] RI_Q_START   = 4'd4;
  localparam logic [IDX_W-1:0] RI_Q_STOP    = 4'd5;
  localparam logic [IDX_W-1:0] RI_SV_BASE   = 4'd6;
  localparam logic [IDX_W-1:0] RI_SV_END    = 4'd7;
  localparam logic [IDX_W-1:0] RI_SV_START  = 4'd8;
  localparam logic [IDX_W-1:0] RI_SV_STOP   = 4'd9;

  localparam int unsigned CMD_W   = 7;
  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_ARM  = 1;
  localparam int unsigned CB_DONE = 2;
  localparam int unsigned CB_ZERO = 3;
  localparam int unsigned CB_RST  = 4;
  localparam int unsigned CB_DIR  = 5;
  localparam int unsigned CB_TX   = 6;

  typedef struct packed {
    logic tx;
    logic dir;
    logic rst;
    logic zero;
    logic clr_done;
    logic set_arm;
    logic set_en;
  } ctl_cmd_t;
endpackage

// File: rtl/dbd_cmd_decode.sv
module dbd_cmd_decode
  import dbd_pkg::*;
(
  input  logic             wen,
  input  logic [IDX_W-1:0] idx,
  input  logic [CMD_W-1:0] wbits,
  output logic             cmd_valid,
  output ctl_cmd_t         cmd,
  output logic             wr_load,
  output logic             wr_end,
  output logic             wr_qstart,
  output logic             wr_qstop
);
  always_comb begin
    cmd_valid    = wen && (idx == RI_CSR);
    cmd.set_en   = wbits[CB_EN];
    cmd.set_arm  = wbits[CB_ARM];
    cmd.clr_done = wbits[CB_DONE];
    cmd.zero     = wbits[CB_ZERO];
    cmd.rst      = wbits[CB_RST];
    cmd.dir      = wbits[CB_DIR];
    cmd.tx       = wbits[CB_TX];
    wr_load      = wen && (idx == RI_PTR_LOAD);
    wr_end       = wen && (idx == RI_END);
    wr_qstart    = wen && (idx == RI_Q_START);
    wr_qstop     = wen && (idx == RI_Q_STOP);
  end
endmodule

// File: rtl/dbd_flags.sv
module dbd_flags
  import dbd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  ctl_cmd_t cmd,
  input  logic     evt_end,
  input  logic     evt_err,
  output logic     en_q,
  output logic     arm_q,
  output logic     done_q,
  output logic     err_q,
  output logic     dir_q,
  output logic     tx_q,
  output logic     promote
);
  logic en_d, arm_d, done_d, err_d, dir_d, tx_d;

  assign promote = evt_end && arm_q;

  always_comb begin
    en_d   = en_q;
    arm_d  = arm_q;
    done_d = done_q;
    err_d  = err_q;
    dir_d  = dir_q;
    tx_d   = tx_q;
    if (evt_err) begin
      en_d  = 1'b0;
      err_d = 1'b1;
    end
    if (evt_end) begin
      done_d = 1'b1;
      if (arm_q) arm_d = 1'b0;
      else       en_d  = 1'b0;
    end
    if (cmd_valid) begin
      dir_d = cmd.dir;
      tx_d  = cmd.tx;
      if (cmd.rst) begin
        en_d  = 1'b0;
        arm_d = 1'b0;
        err_d = 1'b0;
      end
      // a buffer end in the same cycle outranks the clear
      if (cmd.clr_done && !evt_end) done_d = 1'b0;
      if (cmd.set_arm) arm_d = 1'b1;
      if (cmd.set_en)  en_d  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      arm_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      dir_q  <= 1'b0;
      tx_q   <= 1'b0;
    end else begin
      en_q   <= en_d;
      arm_q  <= arm_d;
      done_q <= done_d;
      err_q  <= err_d;
      dir_q  <= dir_d;
      tx_q   <= tx_d;
    end
  end
endmodule

// File: rtl/dbd_ptr_engine.sv
module dbd_ptr_engine #(
  parameter int unsigned AW         = 32,
  parameter int unsigned BEAT_BYTES = 4,
  parameter bit          HAS_FLAG   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_q,
  input  logic          tx_q,
  input  logic          promote,
  input  logic          zero,
  input  logic          wr_load,
  input  logic          wr_end,
  input  logic          wr_qstart,
  input  logic          wr_qstop,
  input  logic [AW-1:0] wdata,
  input  logic          mem_ready,
  input  logic          mem_err,
  input  logic          mem_eop,
  output logic          mem_valid,
  output logic          evt_end,
  output logic          evt_err,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] end_q,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] stop_q,
  output logic [AW-1:0] sv_base_q,
  output logic [AW-1:0] sv_end_q,
  output logic [AW-1:0] sv_start_q,
  output logic [AW-1:0] sv_stop_q
);
  localparam int unsigned FLAG = AW - 1;
  localparam logic [AW-1:0] STEP = AW'(BEAT_BYTES);

  logic [AW-1:0] ptr_inc, ptr_m, end_m, inc_m, sv_end_d;
  logic          beat;

  assign ptr_inc = ptr_q + STEP;

  generate
    if (HAS_FLAG) begin : g_flag
      assign ptr_m    = tx_q ? {1'b0, ptr_q[FLAG-1:0]}   : ptr_q;
      assign end_m    = tx_q ? {1'b0, end_q[FLAG-1:0]}   : end_q;
      assign inc_m    = tx_q ? {1'b0, ptr_inc[FLAG-1:0]} : ptr_inc;
      assign sv_end_d = tx_q ? {end_q[FLAG], ptr_inc[FLAG-1:0]} : ptr_inc;
    end else begin : g_plain
      assign ptr_m    = ptr_q;
      assign end_m    = end_q;
      assign inc_m    = ptr_inc;
      assign sv_end_d = ptr_inc;
    end
  endgenerate

  assign mem_valid = en_q && (ptr_m != end_m);
  assign beat      = mem_valid && mem_ready;
  assign evt_err   = beat && mem_err;
  assign evt_end   = beat && !mem_err && ((inc_m == end_m) || mem_eop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      base_q     <= '0;
      end_q      <= '0;
      start_q    <= '0;
      stop_q     <= '0;
      sv_base_q  <= '0;
      sv_end_q   <= '0;
      sv_start_q <= '0;
      sv_stop_q  <= '0;
    end else begin
      if (beat && !mem_err) ptr_q <= ptr_inc;
      if (evt_end) begin
        sv_base_q <= base_q;
        sv_end_q  <= sv_end_d;
        if (promote) begin
          ptr_q      <= start_q;
          base_q     <= start_q;
          end_q      <= stop_q;
          sv_start_q <= start_q;
          sv_stop_q  <= stop_q;
        end
      end
      if (zero) begin
        ptr_q   <= '0;
        base_q  <= '0;
        end_q   <= '0;
        start_q <= '0;
        stop_q  <= '0;
      end
      if (wr_load) begin
        ptr_q  <= wdata;
        base_q <= wdata;
      end
      if (wr_end)    end_q   <= wdata;
      if (wr_qstart) start_q <= wdata;
      if (wr_qstop)  stop_q  <= wdata;
    end
  end
endmodule

// File: rtl/chain_dma_channel.sv
module chain_dma_channel
  import dbd_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned BEAT_BYTES = 4,
  parameter bit          HAS_FLAG   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wen,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_write,
  input  logic             mem_err,
  input  logic             mem_eop,
  output logic             irq
);
  ctl_cmd_t      cmd;
  logic          cmd_valid, wr_load, wr_end, wr_qstart, wr_qstop;
  logic          en_q, arm_q, done_q, err_q, dir_q, tx_q, promote;
  logic          evt_end, evt_err;
  logic [AW-1:0] ptr_q, base_q, end_q, start_q, stop_q;
  logic [AW-1:0] sv_base_q, sv_end_q, sv_start_q, sv_stop_q;

  dbd_cmd_decode u_dec (
    .wen       (reg_wen),
    .idx       (reg_addr),
    .wbits     (reg_wdata[CMD_W-1:0]),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .wr_load   (wr_load),
    .wr_end    (wr_end),
    .wr_qstart (wr_qstart),
    .wr_qstop  (wr_qstop)
  );

  dbd_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .evt_end   (evt_end),
    .evt_err   (evt_err),
    .en_q      (en_q),
    .arm_q     (arm_q),
    .done_q    (done_q),
    .err_q     (err_q),
    .dir_q     (dir_q),
    .tx_q      (tx_q),
    .promote   (promote)
  );

  dbd_ptr_engine #(
    .AW         (AW),
    .BEAT_BYTES (BEAT_BYTES),
    .HAS_FLAG   (HAS_FLAG)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .tx_q       (tx_q),
    .promote    (promote),
    .zero       (cmd_valid && cmd.zero),
    .wr_load    (wr_load),
    .wr_end     (wr_end),
    .wr_qstart  (wr_qstart),
    .wr_qstop   (wr_qstop),
    .wdata      (reg_wdata),
    .mem_ready  (mem_ready),
    .mem_err    (mem_err),
    .mem_eop    (mem_eop),
    .mem_valid  (mem_valid),
    .evt_end    (evt_end),
    .evt_err    (evt_err),
    .ptr_q      (ptr_q),
    .base_q     (base_q),
    .end_q      (end_q),
    .start_q    (start_q),
    .stop_q     (stop_q),
    .sv_base_q  (sv_base_q),
    .sv_end_q   (sv_end_q),
    .sv_start_q (sv_start_q),
    .sv_stop_q  (sv_stop_q)
  );

  assign mem_addr  = ptr_q;
  assign mem_write = ~dir_q;
  assign irq       = done_q | err_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RI_CSR:      reg_rdata = AW'({tx_q, dir_q, 1'b0, err_q, done_q, arm_q, en_q});
      RI_PTR:      reg_rdata = ptr_q;
      RI_PTR_LOAD: reg_rdata = base_q;
      RI_END:      reg_rdata = end_q;
      RI_Q_START:  reg_rdata = start_q;
      RI_Q_STOP:   reg_rdata = stop_q;
      RI_SV_BASE:  reg_rdata = sv_base_q;
      RI_SV_END:   reg_rdata = sv_end_q;
      RI_SV_START: reg_rdata = sv_start_q;
      RI_SV_STOP:  reg_rdata = sv_stop_q;
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbd_chk.sv
module dbd_chk #(
  parameter int unsigned AW         = 32,
  parameter int unsigned BEAT_BYTES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wen,
  input logic [3:0]    reg_addr,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_err,
  input logic [AW-1:0] mem_addr,
  input logic          en_q,
  input logic          arm_q,
  input logic          done_q,
  input logic          err_q,
  input logic          evt_end,
  input logic [AW-1:0] start_q
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !reg_wen) |=> (mem_valid && $stable(mem_addr)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_err && !evt_end && !reg_wen)
      |=> (mem_addr == $past(mem_addr) + AW'(BEAT_BYTES)));

  p_err_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_err && !reg_wen) |=> (!en_q && err_q && !mem_valid));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(reg_wen && reg_addr == 4'd0)) |=> done_q);

  p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_end && !arm_q && !reg_wen) |=> (!mem_valid && !en_q));

  p_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_end && arm_q && !reg_wen) |=> (mem_addr == $past(start_q) && !arm_q));
endmodule

bind chain_dma_channel dbd_chk #(.AW(AW), .BEAT_BYTES(BEAT_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wen   (reg_wen),
  .reg_addr  (reg_addr),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_err   (mem_err),
  .mem_addr  (mem_addr),
  .en_q      (en_q),
  .arm_q     (arm_q),
  .done_q    (done_q),
  .err_q     (err_q),
  .evt_end   (evt_end),
  .start_q   (start_q)
);

// File: tb/chain_dma_channel_test.sv
`timescale 1ns/1ps
module chain_dma_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic        mem_write;
  logic        mem_err = 1'b0;
  logic        mem_eop = 1'b0;
  logic        irq;

  always #4 clk = ~clk;

  chain_dma_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_write(mem_write),
    .mem_err(mem_err), .mem_eop(mem_eop), .irq(irq)
  );

  typedef struct {
    logic [31:0] addr;
    bit          err;
    bit          eop;
    bit          gap;
    string       req;
  } beat_t;

  beat_t exp_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    rdy_toggle = 1'b0;
  bit    finished = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] a, bit e, bit p, bit g, string r);
    beat_t it;
    it.addr = a; it.err = e; it.eop = p; it.gap = g; it.req = r;
    exp_q.push_back(it);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: drives ready, compares accepted beats with the scoreboard
  initial begin
    int          cnt = 0;
    int          prev_cnt = -10;
    bit          stall_pend = 1'b0;
    logic [31:0] stall_addr = '0;
    beat_t       it;
    forever begin
      @(negedge clk);
      cnt++;
      mem_ready = rdy_toggle ? ~mem_ready : 1'b1;
      #1;
      mem_err = 1'b0;
      mem_eop = 1'b0;
      if (stall_pend) begin
        check("R3 valid held after stall", {31'd0, mem_valid}, 32'd1);
        check("R3 address held after stall", mem_addr, stall_addr);
        stall_pend = 1'b0;
      end
      if (rst_n && mem_valid && mem_ready) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R4 unexpected beat actual=%h expected=none", mem_addr);
        end else begin
          it = exp_q.pop_front();
          check(it.req, mem_addr, it.addr);
          if (it.gap) check("R5 back-to-back chain beat", cnt - prev_cnt, 1);
          mem_err = it.err;
          mem_eop = it.eop;
          prev_cnt = cnt;
        end
      end else if (rst_n && mem_valid) begin
        stall_pend = 1'b1;
        stall_addr = mem_addr;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 valid after reset", {31'd0, mem_valid}, 32'd0);
    rst_n = 1'b1;
    rd(4'd0, v); check("R1 status after reset", v, 32'h0);

    // chained pair, armed
    wr(4'd2, 32'h1000);
    wr(4'd3, 32'h1010);
    wr(4'd4, 32'h2000);
    wr(4'd5, 32'h2008);
    rd(4'd1, v); check("R2 pointer load readback", v, 32'h1000);
    push(32'h1000, 0, 0, 0, "R2 beat 0");
    push(32'h1004, 0, 0, 0, "R2 beat 1");
    push(32'h1008, 0, 0, 0, "R2 beat 2");
    push(32'h100C, 0, 0, 0, "R2 beat 3");
    push(32'h2000, 0, 0, 1, "R5 queued beat 0");
    push(32'h2004, 0, 0, 0, "R5 queued beat 1");
    wr(4'd0, 32'h3);
    check("R11 device-to-memory sets mem_write", {31'd0, mem_write}, 32'd1);
    wait_drain();
    rd(4'd0, v); check("R4 status after chained stop", v, 32'h4);
    rd(4'd1, v); check("R4 pointer equals end", v, 32'h2008);
    rd(4'd6, v); check("R6 saved base", v, 32'h2000);
    rd(4'd7, v); check("R6 saved end", v, 32'h2008);
    rd(4'd8, v); check("R6 saved queued start", v, 32'h2000);
    rd(4'd9, v); check("R6 saved queued stop", v, 32'h2008);
    check("R9 irq on done", {31'd0, irq}, 32'd1);
    repeat (6) @(negedge clk);
    check("R9 irq sticky", {31'd0, irq}, 32'd1);
    wr(4'd0, 32'h4);
    rd(4'd0, v); check("R9 done cleared", v, 32'h0);
    check("R9 irq cleared", {31'd0, irq}, 32'd0);

    // back-pressure
    rdy_toggle = 1'b1;
    wr(4'd2, 32'h3000);
    wr(4'd3, 32'h3010);
    push(32'h3000, 0, 0, 0, "R3 beat 0");
    push(32'h3004, 0, 0, 0, "R3 beat 1");
    push(32'h3008, 0, 0, 0, "R3 beat 2");
    push(32'h300C, 0, 0, 0, "R3 beat 3");
    wr(4'd0, 32'h1);
    wait_drain();
    rdy_toggle = 1'b0;
    rd(4'd0, v); check("R4 single buffer stop status", v, 32'h5 & 32'h4);
    wr(4'd0, 32'h4);

    // early packet end
    wr(4'd2, 32'h4000);
    wr(4'd3, 32'h4040);
    push(32'h4000, 0, 0, 0, "R7 beat 0");
    push(32'h4004, 0, 0, 0, "R7 beat 1");
    push(32'h4008, 0, 1, 0, "R7 last beat");
    wr(4'd0, 32'h1);
    wait_drain();
    check("R7 no request after eop", {31'd0, mem_valid}, 32'd0);
    rd(4'd6, v); check("R7 saved base", v, 32'h4000);
    rd(4'd7, v); check("R7 saved end short", v, 32'h400C);
    rd(4'd1, v); check("R7 pointer after eop", v, 32'h400C);
    rd(4'd0, v); check("R7 status", v, 32'h4);
    wr(4'd0, 32'h4);

    // transmit mode with flag in bit 31
    wr(4'd0, 32'h60);
    check("R11 memory-to-device clears mem_write", {31'd0, mem_write}, 32'd0);
    wr(4'd2, 32'h5000);
    wr(4'd3, 32'h8000_5008);
    push(32'h5000, 0, 0, 0, "R8 beat 0");
    push(32'h5004, 0, 0, 0, "R8 beat 1");
    wr(4'd0, 32'h61);
    wait_drain();
    check("R8 stops at flagged end", {31'd0, mem_valid}, 32'd0);
    rd(4'd7, v); check("R8 saved end keeps flag", v, 32'h8000_5008);
    rd(4'd1, v); check("R8 pointer", v, 32'h5008);
    rd(4'd0, v); check("R8 status", v, 32'h64);
    wr(4'd0, 32'h4);

    // bus error with armed continuation
    wr(4'd2, 32'h6000);
    wr(4'd3, 32'h6010);
    wr(4'd4, 32'h7000);
    wr(4'd5, 32'h7010);
    push(32'h6000, 0, 0, 0, "R10 beat 0");
    push(32'h6004, 1, 0, 0, "R10 error beat");
    wr(4'd0, 32'h3);
    wait_drain();
    check("R10 no request after error", {31'd0, mem_valid}, 32'd0);
    rd(4'd0, v); check("R10 status after error", v, 32'hA);
    rd(4'd1, v); check("R10 pointer not advanced", v, 32'h6004);
    check("R10 irq on bus error", {31'd0, irq}, 32'd1);

    // channel reset, zeroing, ordering
    wr(4'd0, 32'h1C);
    rd(4'd0, v); check("R1 status after reset command", v, 32'h0);
    check("R1 irq after reset command", {31'd0, irq}, 32'd0);
    rd(4'd1, v); check("R12 pointer zeroed", v, 32'h0);
    rd(4'd3, v); check("R12 end zeroed", v, 32'h0);
    rd(4'd4, v); check("R12 queued start zeroed", v, 32'h0);
    rd(4'd5, v); check("R12 queued stop zeroed", v, 32'h0);
    wr(4'd0, 32'h11);
    rd(4'd0, v); check("R1 set applied after reset", v, 32'h1);
    check("R1 empty buffer issues nothing", {31'd0, mem_valid}, 32'd0);
    wr(4'd0, 32'h10);
    rd(4'd0, v); check("R1 reset clears enable", v, 32'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule